// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the arithmetic and logic unit of a sixteen-bit two-operand register machine, paired with the status register that holds its four condition flags. It receives two operands: the source and the destination's current value. It also receives a four-bit operation code, a byte/word select and a flag that says the destination is the status register. The carry used by the carry-consuming operations is the C bit of the status register itself.

Each cycle the block produces the operation result combinationally. It also asserts a write strobe when that result should be stored into a general destination register. On the next rising clock edge it commits new flags into the status register. If the status register is the destination of a writing operation, it stores the whole result there instead.

Operations differ in which flags they touch. The move and bit-set/bit-clear group touches none. The logical AND group forces V low. Exclusive-OR and all arithmetic operations, including a packed-decimal add, rewrite all four flags. Byte mode narrows both the result and the flag evaluation to the low eight bits.

Top module: `bw_alu_sr`

## Requirements
- R1: An active-low asynchronous reset clears the status register output `sr_q` to 0x0000.
- R2: Operation codes are 4=move, 5=add, 6=add with carry, 7=subtract with carry, 8=subtract, 9=compare, A=decimal add, B=bit test, C=bit clear, D=bit set, E=exclusive-or, F=and. `wr_en` is high only for a writing operation (every code 4..F except 9 and B) whose destination is not the status register.
- R3: Add computes src+dst and add-with-carry computes src+dst+C. V is signed overflow, C is the carry out of the top bit, N is the result's top bit and Z is set for a zero result.
- R4: Subtract computes dst+~src+1 and subtract-with-carry computes dst+~src+C. Compare computes the same as subtract and never writes. V is signed overflow and C=1 means no borrow. N and Z follow the result.
- R5: Decimal add treats src, dst and C as packed BCD. C is set when the decimal sum exceeds 9999 (word) or 99 (byte). V is set when both operands' top bits are equal and the result's top bit differs.
- R6: And (F) and bit test (B) compute src&dst. They clear V, set N and Z from the result, and set C to the inverse of Z.
- R7: Exclusive-or computes src^dst. V is set when both operands are negative, C is the inverse of Z, and N and Z follow the result.
- R8: Move yields src, bit clear yields ~src&dst and bit set yields src|dst. None of these three changes any status bit.
- R9: With `byte_mode`=1 only the low 8 bits take part. Result bits 15:8 are zero, N is bit 7, Z looks at bits 7:0 only and C is the carry out of bit 7.
- R10: When `dst_is_sr`=1 and the operation writes, the full result is loaded into the status register on the clock edge. The flags the operation would have produced are dropped.
- R11: Flags sit at C=bit 0, Z=bit 1, N=bit 2, V=bit 8. A flag update leaves all other status bits unchanged.
- R12: Operation codes 0..3 write nothing and leave the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 = byte operation, 0 = word |
| dst_is_sr | input | 1 | Destination is the status register |
| src | input | 16 | Source operand |
| dst | input | 16 | Current destination operand value |
| result | output | 16 | Operation result (upper byte zero in byte mode) |
| wr_en | output | 1 | Store result into general destination |
| sr_q | output | 16 | Status register contents |

## Verification
The only state is the status register, so a wrong internal value is visible on `sr_q` one edge after the operation that produced it. It also corrupts `result` at once on the next carry-consuming operation. The bench compares both every cycle against a model that works on signed and decimal integers rather than on bit-level adders. A flag error therefore surfaces within one cycle of its cause, not after it has spread.

// File: rtl/bw_alu_sr.sv
module bw_alu_sr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op,
  input  logic        byte_mode,
  input  logic        dst_is_sr,
  input  logic [15:0] src,
  input  logic [15:0] dst,
  output logic [15:0] result,
  output logic        wr_en,
  output logic [15:0] sr_q
);
  localparam logic [3:0] OP_MOV  = 4'h4, OP_ADD = 4'h5, OP_ADDC = 4'h6, OP_SUBC = 4'h7;
  localparam logic [3:0] OP_SUB  = 4'h8, OP_CMP = 4'h9, OP_DADD = 4'hA, OP_BIT  = 4'hB;
  localparam logic [3:0] OP_BIC  = 4'hC, OP_BIS = 4'hD, OP_XOR  = 4'hE, OP_AND  = 4'hF;
  localparam int BIT_C = 0, BIT_Z = 1, BIT_N = 2, BIT_V = 8;

  logic [15:0] mask, s_m, d_m, b_op, r_raw, bcd, sr_d;
  logic [16:0] sum;
  logic        cin, is_sub, is_arith, is_dadd, is_logic, is_xor, valid, writes, upd;
  logic        cy_b, cy_w, nb, zr, sd, ss, sb, f_c, f_v;

  assign mask     = byte_mode ? 16'h00FF : 16'hFFFF;
  assign s_m      = src & mask;
  assign d_m      = dst & mask;
  assign is_sub   = (op == OP_SUBC) || (op == OP_SUB) || (op == OP_CMP);
  assign is_arith = is_sub || (op == OP_ADD) || (op == OP_ADDC);
  assign is_dadd  = (op == OP_DADD);
  assign is_logic = (op == OP_AND) || (op == OP_BIT);
  assign is_xor   = (op == OP_XOR);
  assign valid    = op[3] | op[2];
  assign writes   = valid && (op != OP_CMP) && (op != OP_BIT);
  assign upd      = is_arith || is_dadd || is_logic || is_xor;

  assign b_op = is_sub ? (~s_m & mask) : s_m;
  assign cin  = (op == OP_SUB) || (op == OP_CMP) ? 1'b1 :
                (op == OP_ADDC) || (op == OP_SUBC) ? sr_q[BIT_C] : 1'b0;
  assign sum  = {1'b0, d_m} + {1'b0, b_op} + {16'h0, cin};

  always_comb begin
    logic       cy;
    logic [4:0] dig;
    cy   = sr_q[BIT_C];
    bcd  = 16'h0;
    cy_b = 1'b0;
    for (int i = 0; i < 4; i++) begin
      dig = {1'b0, s_m[4*i +: 4]} + {1'b0, d_m[4*i +: 4]} + {4'h0, cy};
      if (dig > 5'd9) begin
        dig = dig + 5'd6;
        cy  = 1'b1;
      end else begin
        cy  = 1'b0;
      end
      bcd[4*i +: 4] = dig[3:0];
      if (i == 1) cy_b = cy;
    end
    cy_w = cy;
  end

  always_comb begin
    unique case (op)
      OP_MOV:                                r_raw = s_m;
      OP_ADD, OP_ADDC, OP_SUBC, OP_SUB,
      OP_CMP:                                r_raw = sum[15:0];
      OP_DADD:                               r_raw = bcd;
      OP_BIT, OP_AND:                        r_raw = s_m & d_m;
      OP_BIC:                                r_raw = ~s_m & d_m;
      OP_BIS:                                r_raw = s_m | d_m;
      OP_XOR:                                r_raw = s_m ^ d_m;
      default:                               r_raw = 16'h0;
    endcase
  end

  assign result = r_raw & mask;
  assign wr_en  = writes & ~dst_is_sr;

  assign nb = byte_mode ? result[7] : result[15];
  assign zr = (result == 16'h0);
  assign sd = byte_mode ? d_m[7]  : d_m[15];
  assign ss = byte_mode ? s_m[7]  : s_m[15];
  assign sb = byte_mode ? b_op[7] : b_op[15];

  always_comb begin
    f_c = ~zr;
    f_v = 1'b0;
    if (is_arith) begin
      f_c = byte_mode ? sum[8] : sum[16];
      f_v = (sd == sb) && (nb != sd);
    end else if (is_dadd) begin
      f_c = byte_mode ? cy_b : cy_w;
      f_v = (sd == ss) && (nb != sd);
    end else if (is_xor) begin
      f_v = ss & sd;
    end
  end

  always_comb begin
    sr_d = sr_q;
    if (writes && dst_is_sr) begin
      sr_d = result;
    end else if (upd) begin
      sr_d[BIT_C] = f_c;
      sr_d[BIT_Z] = zr;
      sr_d[BIT_N] = nb;
      sr_d[BIT_V] = f_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 16'h0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/bw_alu_sr_chk.sv
module bw_alu_sr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  op,
  input logic        byte_mode,
  input logic        dst_is_sr,
  input logic [15:0] result,
  input logic        wr_en,
  input logic [15:0] sr_q
);
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (sr_q == 16'h0));

  p_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 4'h9) || (op == 4'hB) || (op < 4'h4) || dst_is_sr) |-> !wr_en);

  p_and_clears_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((op == 4'hF) || (op == 4'hB)) && !dst_is_sr) |=> !sr_q[8]);

  p_keep_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (((op == 4'h4) || (op == 4'hC) || (op == 4'hD)) && !dst_is_sr) |=> $stable(sr_q));

  p_byte_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (result[15:8] == 8'h0));

  p_sr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_is_sr && (op >= 4'h4) && (op != 4'h9) && (op != 4'hB)) |=> (sr_q == $past(result)));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op < 4'h4) |=> $stable(sr_q));
endmodule

bind bw_alu_sr bw_alu_sr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op(op), .byte_mode(byte_mode), .dst_is_sr(dst_is_sr),
  .result(result), .wr_en(wr_en), .sr_q(sr_q)
);

// File: tb/bw_alu_sr_tb.sv
module bw_alu_sr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'h0;
  logic        byte_mode = 1'b0;
  logic        dst_is_sr = 1'b0;
  logic [15:0] src = 16'h0, dst = 16'h0;
  logic [15:0] result, sr_q;
  logic        wr_en;

  int checks = 0, errors = 0;
  logic [15:0] msr = 16'h0;
  bit done = 0;

  always #2 clk = ~clk;

  bw_alu_sr dut_i (.clk(clk), .rst_n(rst_n), .op(op), .byte_mode(byte_mode),
    .dst_is_sr(dst_is_sr), .src(src), .dst(dst), .result(result), .wr_en(wr_en), .sr_q(sr_q));

  function automatic int sx(logic [15:0] v, bit b);
    return b ? int'($signed(v[7:0])) : int'($signed(v));
  endfunction

  function automatic int from_bcd(logic [15:0] v);
    return v[3:0] + 10*v[7:4] + 100*v[11:8] + 1000*v[15:12];
  endfunction

  function automatic logic [15:0] to_bcd(int n);
    logic [15:0] r;
    r[3:0] = 4'(n % 10); r[7:4] = 4'((n/10) % 10);
    r[11:8] = 4'((n/100) % 10); r[15:12] = 4'((n/1000) % 10);
    return r;
  endfunction

  function automatic string tag_of(logic [3:0] o, bit b, bit s);
    if (s) return "R10";
    if (b) return "R9";
    case (o)
      4'h5, 4'h6: return "R3";
      4'h7, 4'h8, 4'h9: return "R4";
      4'hA: return "R5";
      4'hB, 4'hF: return "R6";
      4'hE: return "R7";
      4'h4, 4'hC, 4'hD: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input bit b, input bit s_sr,
                       input logic [15:0] s, input logic [15:0] d,
                       output logic [15:0] r, output logic w, output logic [15:0] ns);
    int mask = b ? 'hFF : 'hFFFF;
    int lo = b ? -128 : -32768;
    int hi = b ? 127 : 32767;
    int su = int'(s) & mask, du = int'(d) & mask, c = int'(msr[0]);
    int t = 0, sv = 0, dec = 0;
    bit wr = 0, upd = 0, fc = 0, fv = 0, arith = 0;
    logic [15:0] rr = 16'h0;
    case (o)
      4'h4: begin rr = 16'(su); wr = 1; end
      4'h5: begin t = su + du;     sv = sx(s,b) + sx(d,b);         arith = 1; wr = 1; end
      4'h6: begin t = su + du + c; sv = sx(s,b) + sx(d,b) + c;     arith = 1; wr = 1; end
      4'h7: begin t = du + (~su & mask) + c; sv = sx(d,b) - sx(s,b) - 1 + c; arith = 1; wr = 1; end
      4'h8: begin t = du + (~su & mask) + 1; sv = sx(d,b) - sx(s,b); arith = 1; wr = 1; end
      4'h9: begin t = du + (~su & mask) + 1; sv = sx(d,b) - sx(s,b); arith = 1; end
      4'hA: begin
        dec = from_bcd(16'(su)) + from_bcd(16'(du)) + c;
        fc = b ? (dec > 99) : (dec > 9999);
        rr = to_bcd(dec) & 16'(mask);
        fv = (su[b ? 7 : 15] == du[b ? 7 : 15]) && (rr[b ? 7 : 15] != du[b ? 7 : 15]);
        upd = 1; wr = 1;
      end
      4'hB: begin rr = 16'(su & du); upd = 1; end
      4'hF: begin rr = 16'(su & du); upd = 1; wr = 1; end
      4'hC: begin rr = 16'(~su & du & mask); wr = 1; end
      4'hD: begin rr = 16'(su | du); wr = 1; end
      4'hE: begin rr = 16'(su ^ du); fv = su[b ? 7 : 15] & du[b ? 7 : 15]; upd = 1; wr = 1; end
      default: ;
    endcase
    if (arith) begin
      rr = 16'(t & mask); fc = (t > mask); fv = (sv < lo) || (sv > hi); upd = 1;
    end
    if (o == 4'hB || o == 4'hF || o == 4'hE) fc = (rr == 16'h0) ? 0 : 1;
    r = rr;
    w = wr && !s_sr;
    ns = msr;
    if (wr && s_sr) ns = rr;
    else if (upd) begin
      ns[0] = fc; ns[1] = (rr == 16'h0); ns[2] = rr[b ? 7 : 15]; ns[8] = fv;
    end
  endtask

  task automatic check16(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(logic [3:0] o, bit b, bit s_sr, logic [15:0] s, logic [15:0] d, string tag);
    logic [15:0] er, ens;
    logic ew;
    @(negedge clk);
    op = o; byte_mode = b; dst_is_sr = s_sr; src = s; dst = d;
    #1;
    model(o, b, s_sr, s, d, er, ew, ens);
    check16(tag, "result", result, er);
    check16((o == 4'h9 || o == 4'hB || o < 4'h4 || s_sr) ? "R2" : tag, "wr_en", {15'h0, wr_en}, {15'h0, ew});
    @(posedge clk); #1;
    msr = ens;
    check16(tag, "sr_q", sr_q, ens);
  endtask

  function automatic logic [15:0] rnd_bcd();
    return to_bcd(int'($urandom % 10000));
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check16("R1", "sr_q after reset", sr_q, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    run(4'h5, 1, 0, 16'h00FF, 16'h0001, "R9");
    run(4'h6, 0, 0, 16'h7FFF, 16'h0000, "R3");
    run(4'h8, 0, 0, 16'h1234, 16'h1234, "R4");
    run(4'h9, 0, 0, 16'h0001, 16'h0000, "R4");
    run(4'h7, 0, 0, 16'h0001, 16'h8000, "R4");
    run(4'hA, 0, 0, 16'h9999, 16'h0001, "R5");
    run(4'hA, 1, 0, 16'h0050, 16'h0049, "R5");
    run(4'hE, 0, 0, 16'h8000, 16'h8000, "R7");
    run(4'hF, 0, 0, 16'h00F0, 16'h0F00, "R6");
    run(4'hB, 1, 0, 16'h0080, 16'h0181, "R6");
    run(4'h4, 0, 1, 16'hF0F0, 16'h0000, "R11");
    run(4'h8, 0, 0, 16'h0001, 16'h0002, "R11");
    run(4'h5, 0, 1, 16'h0003, sr_q, "R10");
    run(4'hC, 0, 0, 16'h00FF, 16'h1234, "R8");
    run(4'hD, 1, 0, 16'hAB0F, 16'hCD30, "R8");
    run(4'h2, 0, 0, 16'hFFFF, 16'hFFFF, "R12");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] o = 4'($urandom);
      bit b = 1'($urandom);
      bit s_sr = ($urandom % 8) == 0;
      logic [15:0] s = 16'($urandom), d = 16'($urandom);
      if (o == 4'hA) begin s = rnd_bcd(); d = rnd_bcd(); end
      run(o, b, s_sr, s, d, tag_of(o, b, s_sr));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule